// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a general-purpose timer built around a counter of parameterised width (16 bits by default). A programmable prescaler divides the input clock. The counter runs up to a reload limit and back, and several compare channels turn the counter value into output waveforms. The counter can run edge-aligned, counting up or down, or centre-aligned, rising to the limit and falling back to zero. In centre-aligned operation the alignment field picks which turning point raises the update flag.

Each channel compares the counter against its own compare value. It then drives its pin in one of eight ways: it can hold its state, set, clear or invert the pin on a match, force the pin low or high, or produce a PWM waveform of either polarity. Software configures everything through a simple write port. Optionally, writes to the reload and compare values can be held in shadow registers and applied only at the next update, so that a period in progress is never cut short.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count is 0, the update flag, every pin and every match flag are low, and every channel is in hold mode (code 0), so its pin stays low even while the counter runs and matches occur.
- R2: While the run bit is clear, the counter and the prescaler do not advance. Clearing the run bit freezes the count at its current value.
- R3: With prescale value P, the counter advances once every P+1 clocks. The update flag lasts exactly one clock.
- R4: In edge mode with direction up, the count goes 0, 1, ... L, then 0, where L is the active reload value. The update flag is high for exactly the clock in which the wrapped 0 is shown.
- R5: In edge mode with direction down, the count steps down to 0 and then reloads to L. The update flag is high in the clock that shows the reloaded L. Starting from 0, the first advance reloads.
- R6: In centre modes the count runs 0, 1, ... L, L-1, ... 1, 0, 1, ... Neither turning point is shown twice in a row.
- R7: Centre alignment code 1 flags an update when the falling count reaches 0. Code 2 flags when the rising count reaches L. Code 3 flags on both.
- R8: With preload off, a new reload value applies from the next advance. A count already above the new limit wraps to 0 (up-counting) on that advance.
- R9: With preload on, reload and compare writes take effect only at the next update event. The period in progress keeps the old values.
- R10: PWM-below mode (code 6) drives the pin high while count < compare. PWM-above mode (code 7) drives it high while count > compare. The pin reflects the count one clock later.
- R11: Set (code 1), clear (code 2) and toggle (code 3) act one clock after an advance that lands on the compare value. The match flag pulses for that clock in every mode, including hold.
- R12: Force-low (code 4) and force-high (code 5) drive the pin regardless of the count.
- R13: A pin is low whenever its output-enable bit is clear, whatever the channel's internal state.
- R14: Write map: address 0 is control, with bit0 run, bit1 direction (1 = down), bits3:2 alignment (0 = edge) and bit4 preload. Address 1 is the prescale value, 2 the reload value, 3 the output enables (bit i for channel i), 4+i the mode of channel i and 4+N+i the compare value of channel i, where N is the channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | W | Write data |
| cnt_o | output | W | Current counter value |
| upd_o | output | 1 | One-clock update event flag |
| ch_pin_o | output | NUM_CH | Channel output pins |
| ch_match_o | output | NUM_CH | One-clock match flag per channel |

## Verification
A register write takes effect in the clock after the write edge. The counter shows its new value one clock after a prescaler tick, and the update flag is high in that same clock. Pins and match flags trail by one further register, so they reflect the count from the previous clock. The bench samples on the falling edge and numbers the samples from the one in which the run bit first takes effect. It derives each expected count from that sample index and checks the pin and match outputs against the count expected one sample earlier.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
// Shared types and register addresses for the compare timer.
// Assumes the data word is at least 5 bits wide so the control fields fit.
package cmp_timer_pkg;

    typedef enum logic [2:0] {
        OC_HOLD    = 3'd0,
        OC_SET     = 3'd1,
        OC_CLEAR   = 3'd2,
        OC_TOGGLE  = 3'd3,
        OC_LOW     = 3'd4,
        OC_HIGH    = 3'd5,
        OC_PWM_LO  = 3'd6,
        OC_PWM_HI  = 3'd7
    } oc_mode_e;

    typedef enum logic [1:0] {
        ALN_EDGE     = 2'd0,
        ALN_CTR_DN   = 2'd1,
        ALN_CTR_UP   = 2'd2,
        ALN_CTR_BOTH = 2'd3
    } align_e;

    typedef struct packed {
        logic   preload;
        align_e align;
        logic   down;
        logic   run;
    } ctrl_t;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PSC   = 1;
    localparam int ADDR_ARR   = 2;
    localparam int ADDR_OE    = 3;
    localparam int ADDR_MODE0 = 4;

endpackage

// File: rtl/cmp_timer_prescaler.sv
`timescale 1ns/1ps
// Clock divider: emits one tick every (div+1) clocks while run is high.
// Assumes div may change at any time; a count already past div ticks at once.
module cmp_timer_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] pre_q;

    assign tick = run && (pre_q >= div);

    // Advance the divider count, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (run)
            pre_q <= tick ? '0 : pre_q + ONE;
    end
endmodule

// File: rtl/cmp_timer_counter.sv
`timescale 1ns/1ps
// Main counter: edge-aligned up/down or centre-aligned up/down counting,
// with an update event chosen by the alignment mode.
// Assumes arr is the already-selected (shadow or active) reload limit.
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  align_e       align,
    input  logic         down_sel,
    input  logic [W-1:0] arr,
    output logic [W-1:0] cnt_q,
    output logic         upd_now,
    output logic         upd_q,
    output logic         step_q
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         dn_q;
    logic         nxt_dn;
    logic         ev_top;
    logic         ev_bot;
    logic [W-1:0] nxt;

    // Next count, next phase and the turning-point events.
    always_comb begin
        nxt    = cnt_q;
        nxt_dn = dn_q;
        ev_top = 1'b0;
        ev_bot = 1'b0;
        if (align == ALN_EDGE) begin
            nxt_dn = 1'b0;
            if (!down_sel) begin
                if (cnt_q >= arr) begin
                    nxt    = '0;
                    ev_bot = 1'b1;
                end else begin
                    nxt = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    nxt    = arr;
                    ev_top = 1'b1;
                end else begin
                    nxt = cnt_q - ONE;
                end
            end
        end else if (!dn_q) begin
            if (cnt_q >= arr) begin
                nxt    = (arr == '0) ? '0 : arr - ONE;
                nxt_dn = 1'b1;
                ev_bot = (arr == ONE);
            end else begin
                nxt    = cnt_q + ONE;
                ev_top = (nxt == arr);
            end
        end else begin
            if (cnt_q == '0) begin
                nxt    = (arr == '0) ? '0 : ONE;
                nxt_dn = 1'b0;
                ev_top = (arr == ONE);
            end else begin
                nxt    = cnt_q - ONE;
                ev_bot = (cnt_q == ONE);
            end
        end
    end

    // Filter the turning-point events by the alignment selection.
    always_comb begin
        if (align == ALN_EDGE)
            upd_now = tick && (ev_top || ev_bot);
        else
            upd_now = tick && ((ev_bot && align != ALN_CTR_UP) ||
                               (ev_top && align != ALN_CTR_DN));
    end

    // Register the count, phase, update flag and step marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dn_q   <= 1'b0;
            upd_q  <= 1'b0;
            step_q <= 1'b0;
        end else begin
            if (tick) begin
                cnt_q <= nxt;
                dn_q  <= nxt_dn;
            end
            upd_q  <= upd_now;
            step_q <= tick;
        end
    end
endmodule

// File: rtl/cmp_timer_channel.sv
`timescale 1ns/1ps
// One compare channel: turns count vs compare into a pin level and a match pulse.
// Assumes step is high for one clock after each counter advance.
module cmp_timer_channel
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  oc_mode_e     mode,
    input  logic         oe,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         pin,
    output logic         match
);
    logic out_q;
    logic match_q;
    logic hit;

    assign hit = step && (cnt == cmp);

    // Update the output level according to the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            case (mode)
                OC_SET:    if (hit) out_q <= 1'b1;
                OC_CLEAR:  if (hit) out_q <= 1'b0;
                OC_TOGGLE: if (hit) out_q <= ~out_q;
                OC_LOW:    out_q <= 1'b0;
                OC_HIGH:   out_q <= 1'b1;
                OC_PWM_LO: out_q <= (cnt < cmp);
                OC_PWM_HI: out_q <= (cnt > cmp);
                default:   out_q <= out_q;
            endcase
        end
    end

    assign pin   = oe & out_q;
    assign match = match_q;
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
// Compare timer top: register file, shadow values, prescaler, counter and channels.
// Assumes NUM_CH <= W and that the address space holds 4 + 2*NUM_CH registers.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W      = 16,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      cnt_o,
    output logic              upd_o,
    output logic [NUM_CH-1:0] ch_pin_o,
    output logic [NUM_CH-1:0] ch_match_o
);
    localparam int MODE_BASE = ADDR_MODE0;
    localparam int CCR_BASE  = MODE_BASE + NUM_CH;

    ctrl_t                 ctrl_q;
    logic [W-1:0]          psc_q;
    logic [W-1:0]          arr_q;
    logic [W-1:0]          arr_act_q;
    logic [W-1:0]          arr_eff;
    logic [NUM_CH-1:0]     oe_q;
    oc_mode_e              mode_q    [NUM_CH];
    logic [W-1:0]          ccr_q     [NUM_CH];
    logic [W-1:0]          ccr_act_q [NUM_CH];
    logic [W-1:0]          ccr_eff   [NUM_CH];
    logic [NUM_CH*3-1:0]   mode_flat;
    logic [NUM_CH*W-1:0]   ccr_flat;
    logic                  tick;
    logic                  upd_now;
    logic                  step_q;

    // Capture register writes from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            arr_q  <= '1;
            oe_q   <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                mode_q[i] <= OC_HOLD;
                ccr_q[i]  <= '0;
            end
        end else if (wr_en) begin
            case (int'(wr_addr))
                ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data[4:0]);
                ADDR_PSC:  psc_q  <= wr_data;
                ADDR_ARR:  arr_q  <= wr_data;
                ADDR_OE:   oe_q   <= wr_data[NUM_CH-1:0];
                default:   ;
            endcase
            for (int i = 0; i < NUM_CH; i++) begin
                if (int'(wr_addr) == MODE_BASE + i)
                    mode_q[i] <= oc_mode_e'(wr_data[2:0]);
                if (int'(wr_addr) == CCR_BASE + i)
                    ccr_q[i] <= wr_data;
            end
        end
    end

    // Copy shadow values to the active set when preload is off or at an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_act_q <= '1;
            for (int i = 0; i < NUM_CH; i++)
                ccr_act_q[i] <= '0;
        end else if (!ctrl_q.preload || upd_now) begin
            arr_act_q <= arr_q;
            for (int i = 0; i < NUM_CH; i++)
                ccr_act_q[i] <= ccr_q[i];
        end
    end

    assign arr_eff = ctrl_q.preload ? arr_act_q : arr_q;

    cmp_timer_prescaler #(.W(W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .div   (psc_q),
        .tick  (tick)
    );

    cmp_timer_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .align    (ctrl_q.align),
        .down_sel (ctrl_q.down),
        .arr      (arr_eff),
        .cnt_q    (cnt_o),
        .upd_now  (upd_now),
        .upd_q    (upd_o),
        .step_q   (step_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ccr_eff[g]            = ctrl_q.preload ? ccr_act_q[g] : ccr_q[g];
        assign mode_flat[g*3 +: 3]   = mode_q[g];
        assign ccr_flat[g*W +: W]    = ccr_eff[g];

        cmp_timer_channel #(.W(W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode_q[g]),
            .oe    (oe_q[g]),
            .step  (step_q),
            .cnt   (cnt_o),
            .cmp   (ccr_eff[g]),
            .pin   (ch_pin_o[g]),
            .match (ch_match_o[g])
        );
    end
endmodule

// File: rtl/cmp_timer_checker.sv
`timescale 1ns/1ps
// Property checker for the compare timer, attached by bind.
// Assumes it sees the registered control fields and effective compare values.
module cmp_timer_checker #(
    parameter int W      = 16,
    parameter int NUM_CH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                down,
    input logic [1:0]          align,
    input logic [W-1:0]        arr_eff,
    input logic [W-1:0]        cnt,
    input logic                upd,
    input logic [NUM_CH-1:0]   oe,
    input logic [NUM_CH*3-1:0] mode_flat,
    input logic [NUM_CH*W-1:0] ccr_flat,
    input logic [NUM_CH-1:0]   pin,
    input logic [NUM_CH-1:0]   match
);
    localparam logic [W-1:0] ONE = W'(1);

    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && align == 2'd0 && !down && $past(align == 2'd0 && !down)) |-> cnt == '0);

    p_down_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && align == 2'd0 && down && $past(align == 2'd0 && down)) |-> cnt == $past(arr_eff));

    p_center_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (align != 2'd0 && $past(align != 2'd0) && arr_eff == $past(arr_eff) &&
         $past(arr_eff) != '0 && $past(cnt) <= $past(arr_eff))
        |-> (cnt == $past(cnt) || cnt == $past(cnt) + ONE || cnt + ONE == $past(cnt)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_match_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
            match[g] |-> $past(cnt == ccr_flat[g*W +: W]));

        p_pwm_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[g*3 +: 3]) == 3'd6 && oe[g])
            |-> pin[g] == ($past(cnt) < $past(ccr_flat[g*W +: W])));

        p_force_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[g*3 +: 3]) == 3'd5 && oe[g]) |-> pin[g]);

        p_force_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[g*3 +: 3]) == 3'd4) |-> !pin[g]);
    end
endmodule

bind cmp_timer cmp_timer_checker #(.W(W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .down      (ctrl_q.down),
    .align     (ctrl_q.align),
    .arr_eff   (arr_eff),
    .cnt       (cnt_o),
    .upd       (upd_o),
    .oe        (oe_q),
    .mode_flat (mode_flat),
    .ccr_flat  (ccr_flat),
    .pin       (ch_pin_o),
    .match     (ch_match_o)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
// Directed bench for the compare timer; one task per scenario.
module test_cmp_timer;
    localparam int W   = 16;
    localparam int NCH = 4;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [W-1:0]   wr_data = '0;
    logic [W-1:0]   cnt_o;
    logic           upd_o;
    logic [NCH-1:0] ch_pin_o;
    logic [NCH-1:0] ch_match_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmp_timer #(.W(W), .NUM_CH(NCH), .ADDR_W(AW)) i_cmp_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cnt_o      (cnt_o),
        .upd_o      (upd_o),
        .ch_pin_o   (ch_pin_o),
        .ch_match_o (ch_match_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 count", cnt_o, 0);
        chk("R1 update", upd_o, 0);
        chk("R1 pins", ch_pin_o, 0);
        chk("R1 match", ch_match_o, 0);
        wr(2, 3); wr(3, 15); wr(8, 1); wr(0, 1);
        for (int k = 0; k < 10; k++) begin
            chk("R1 hold pins", ch_pin_o, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_stop;
        logic [W-1:0] held;
        do_reset();
        wr(2, 9);
        repeat (5) begin
            chk("R2 idle", cnt_o, 0);
            @(negedge clk);
        end
        wr(0, 1);
        repeat (4) @(negedge clk);
        chk("R2 running", cnt_o, 4);
        wr(0, 0);
        held = cnt_o;
        chk("R2 stop value", held, 5);
        repeat (5) begin
            @(negedge clk);
            chk("R2 held", cnt_o, held);
        end
    endtask

    task automatic t_up;
        do_reset();
        wr(2, 4); wr(0, 1);
        for (int k = 0; k < 15; k++) begin
            chk("R4 count", cnt_o, k % 5);
            chk("R4 update", upd_o, (k > 0 && k % 5 == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_down;
        do_reset();
        wr(2, 5); wr(0, 3);
        for (int k = 0; k < 16; k++) begin
            chk("R5 R14 count", cnt_o, (k == 0) ? 0 : 5 - ((k - 1) % 6));
            chk("R5 update", upd_o, (k >= 1 && (k - 1) % 6 == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_center(input int m);
        do_reset();
        wr(2, 3); wr(0, 1 | (m << 2));
        for (int k = 0; k < 17; k++) begin
            int  p;
            logic top, bot, eu;
            p   = k % 6;
            top = (p == 3);
            bot = (p == 0 && k > 0);
            eu  = (m == 1) ? bot : (m == 2) ? top : (top || bot);
            chk("R6 centre count", cnt_o, (p <= 3) ? p : 6 - p);
            chk("R7 centre update", upd_o, eu);
            @(negedge clk);
        end
    endtask

    task automatic t_psc;
        do_reset();
        wr(1, 2); wr(2, 3); wr(0, 1);
        for (int k = 0; k < 18; k++) begin
            chk("R3 prescaled count", cnt_o, (k / 3) % 4);
            chk("R3 update width", upd_o, (k > 0 && k % 12 == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_noload;
        do_reset();
        wr(2, 7); wr(0, 1);
        while (cnt_o != 5) @(negedge clk);
        wr(2, 3);
        chk("R8 old limit step", cnt_o, 6);
        @(negedge clk);
        chk("R8 early wrap", cnt_o, 0);
        chk("R8 wrap update", upd_o, 1);
        for (int k = 1; k < 7; k++) begin
            @(negedge clk);
            chk("R8 new period", cnt_o, k % 4);
        end
    endtask

    task automatic t_preload;
        int phase, seen_old, seen_new;
        logic [W-1:0] prev, max1;
        do_reset();
        wr(2, 7); wr(8, 5); wr(4, 1); wr(0, 'h11);
        while (cnt_o != 2) @(negedge clk);
        wr(2, 3); wr(8, 2);
        prev = cnt_o; phase = 0; seen_old = 0; seen_new = 0; max1 = '0;
        repeat (20) begin
            @(negedge clk);
            if (ch_match_o[0]) begin
                if (phase == 0) begin
                    chk("R9 old compare", prev, 5);
                    seen_old++;
                end else begin
                    chk("R9 new compare", prev, 2);
                    seen_new++;
                end
            end
            if (phase == 0 && cnt_o == 0) begin
                chk("R9 old reload", prev, 7);
                phase = 1;
            end else if (phase == 1 && cnt_o > max1) begin
                max1 = cnt_o;
            end
            prev = cnt_o;
        end
        chk("R9 old compare seen", seen_old, 1);
        chk("R9 new compare seen", seen_new > 0, 1);
        chk("R9 new reload max", max1, 3);
    endtask

    task automatic t_pwm;
        logic tog, setst;
        do_reset();
        wr(2, 4);
        wr(8, 2); wr(9, 2); wr(10, 3); wr(11, 1);
        wr(4, 6); wr(5, 7); wr(6, 3); wr(7, 1);
        wr(3, 15); wr(0, 1);
        tog = 1'b0; setst = 1'b0;
        for (int k = 0; k < 15; k++) begin
            if (k >= 1) begin
                int c;
                c = (k - 1) % 5;
                if (k >= 2 && c == 3) tog = ~tog;
                if (k >= 2 && c == 1) setst = 1'b1;
                chk("R10 pwm below", ch_pin_o[0], c < 2);
                chk("R10 pwm above", ch_pin_o[1], c > 2);
                chk("R11 toggle", ch_pin_o[2], tog);
                chk("R11 set", ch_pin_o[3], setst);
                chk("R11 match flag", ch_match_o[2], (k >= 2 && c == 3));
            end
            @(negedge clk);
        end
    endtask

    task automatic t_force;
        logic clr;
        do_reset();
        wr(4, 5); wr(5, 4); wr(6, 5); wr(3, 'hE);
        @(negedge clk);
        chk("R13 gated pin", ch_pin_o[0], 0);
        chk("R12 force high", ch_pin_o[2], 1);
        chk("R12 force low", ch_pin_o[1], 0);
        wr(3, 'hF);
        chk("R13 enabled pin", ch_pin_o[0], 1);
        wr(2, 5); wr(10, 3); wr(6, 2); wr(11, 2); wr(0, 1);
        clr = 1'b0;
        for (int k = 0; k < 14; k++) begin
            int c;
            c = (k >= 1) ? (k - 1) % 6 : 0;
            if (k >= 2 && c == 3) clr = 1'b1;
            chk("R11 clear on match", ch_pin_o[2], !clr);
            chk("R11 hold pin", ch_pin_o[3], 0);
            chk("R11 hold match flag", ch_match_o[3], (k >= 2 && c == 2));
            chk("R12 force high running", ch_pin_o[0], 1);
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stop();
        t_up();
        t_down();
        t_center(1);
        t_center(2);
        t_center(3);
        t_psc();
        t_noload();
        t_preload();
        t_pwm();
        t_force();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule